// File: doc/BRIEF.md
# SD Controller Bring-Up Sequencer

This block is a fixed-program bus master that prepares an SPI-mode SD card controller after power-on and then tells the card to enter its idle state. It waits until the clock generator reports lock. It then keeps the controller in reset for a set number of cycles and releases it. After that it issues a short, ordered list of 32-bit writes to a slave with two registers. Register 0 accepts command bytes and register 1 holds the 32-bit argument that goes with them. When the list is finished it parks with its bus quiet and a done flag raised.

The write program has two parts. The first part places a configuration word in the argument register. Its low byte, 0x0B, is the clock divider that takes a 10 MHz controller clock down to about 400 kHz. A command byte of 0xC0 then tells the controller to load its own settings from that register. The second part fills the argument register with all ones and issues the command byte 0x40. A command byte whose two top bits are 01 is passed on to the card; 0x40 is the go-idle command. Any other top-bit pattern, such as the 11 in 0xC0, is handled inside the controller. The argument is always written before the command that uses it.

The SD controller, the SPI signalling and any checking of the card's reply are outside this block. Each write is a single-cycle strobe with no acknowledge. A write is treated as taken in the cycle its strobe is high.

Top module: `sdc_bringup_seq`

## Requirements
- R1: While synchronous reset `rst` is high, and in the cycle after it is released, `wb_stb_o`, `wb_cyc_o`, `wb_we_o` and `done_o` are 0 and `ctl_rst_o` is 1.
- R2: While `clk_locked_i` stays low after reset, the block makes no write strobe, keeps `ctl_rst_o` at 1 and keeps `done_o` at 0, for any number of cycles.
- R3: Call E0 the first rising edge at which `clk_locked_i` is sampled high after reset. `ctl_rst_o` stays 1 after edges E0 to E(HOLD_CYCLES-2) and becomes 0 after edge E(HOLD_CYCLES-1). No strobe occurs while `ctl_rst_o` is 1. The default HOLD_CYCLES is 5, which counts the lock-wait state, so the release comes after E4.
- R4: After edge E(HOLD_CYCLES) (E5 by default) there is a one-cycle write with `wb_adr_o`=1, `wb_dat_o`=0x5556550B, `wb_sel_o`=4'b1111 and `wb_we_o`=1.
- R5: After the next edge (E6) `wb_stb_o` is 0 for exactly one cycle.
- R6: After edges E7, E8 and E9 there are three back-to-back one-cycle writes, in this order: address 0 with data 0x000000C0, address 1 with data 0xFFFFFFFF, and address 0 with data 0x00000040. All four byte selects are set in each. The command byte is in bits 7:0 and the upper bits are zero. Two strobed cycles in a row never use the same address.
- R7: Each bring-up makes exactly four write strobes. The argument register (address 1) is written in the cycle just before each command write, except for the 0xC0 command, which follows a one-cycle gap.
- R8: After edge E10, and from then on until reset, `done_o` is 1 and `wb_stb_o` is 0. Before E10, `done_o` is 0.
- R9: Once lock has been sampled high, the sequence runs to completion with the same timing even if `clk_locked_i` falls again.
- R10: Whenever `wb_stb_o` is 1, `wb_cyc_o` and `wb_we_o` are also 1. Whenever `wb_stb_o` is 0, `wb_cyc_o` is 0.
- R11: Asserting `rst` partway through the sequence brings the outputs back to the R1 state after the next edge. The sequence then starts again from the lock wait and follows the same timeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_locked_i | input | 1 | Clock generator lock indication |
| ctl_rst_o | output | 1 | Reset to the SD controller, active high |
| wb_cyc_o | output | 1 | Bus cycle valid |
| wb_stb_o | output | 1 | Write strobe, one cycle per write |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | 1 | Register select: 0 command, 1 argument |
| wb_dat_o | output | 32 | Write data |
| wb_sel_o | output | 4 | Byte selects |
| done_o | output | 1 | Bring-up finished, sticky until reset |

## Verification
The bench logs every output once per cycle and numbers each sample by how many edges have passed since lock was first seen. The first pattern keeps lock low for a long time, which shows whether lock alone gates the start. The second pattern raises lock and holds it high, which fixes the exact cycle of the reset release, of every write and of the gap. The third pattern lets lock fall right after it is seen, which separates a machine that runs to the end on its own from one that stalls with lock. The last pattern resets the block while a write is in progress and then runs it again. This shows the block returns to its start state rather than resuming partway through.

// File: rtl/sdc_bringup_pkg.sv
`timescale 1ns/1ps
package sdc_bringup_pkg;

  parameter int unsigned SDC_DW = 32;
  parameter int unsigned SDC_AW = 1;
  localparam int unsigned SDC_SW = SDC_DW / 8;

  // number of bus slots in the write program (writes and gaps)
  localparam int unsigned SDC_NSTEPS = 5;
  localparam int unsigned SDC_IW = $clog2(SDC_NSTEPS);

  typedef enum logic [1:0] {
    SQ_WAIT = 2'd0,
    SQ_HOLD = 2'd1,
    SQ_RUN  = 2'd2,
    SQ_DONE = 2'd3
  } sq_state_e;

  typedef struct packed {
    logic              wr;
    logic [SDC_AW-1:0] adr;
    logic [SDC_DW-1:0] dat;
  } bus_step_t;

  function automatic bus_step_t mk_write(input logic [SDC_AW-1:0] a,
                                         input logic [SDC_DW-1:0] d);
    bus_step_t s;
    s.wr  = 1'b1;
    s.adr = a;
    s.dat = d;
    return s;
  endfunction

  function automatic bus_step_t mk_gap();
    bus_step_t s;
    s.wr  = 1'b0;
    s.adr = '0;
    s.dat = '0;
    return s;
  endfunction

endpackage

// File: rtl/sdc_seq_ctrl.sv
`timescale 1ns/1ps
module sdc_seq_ctrl
  import sdc_bringup_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_locked_i,
  output logic              step_go_o,
  output logic [SDC_IW-1:0] step_idx_o,
  output logic              ctl_rst_o,
  output logic              done_o
);

  localparam int unsigned CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST_CNT = CW'(HOLD_CYCLES - 1);
  localparam logic [SDC_IW-1:0] LAST_IDX = SDC_IW'(SDC_NSTEPS - 1);

  sq_state_e         st;
  logic [CW-1:0]     cnt;
  logic [SDC_IW-1:0] idx;
  logic              ctl_rst_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_WAIT;
      cnt       <= '0;
      idx       <= '0;
      ctl_rst_q <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      case (st)
        SQ_WAIT: begin
          if (clk_locked_i) begin
            st  <= SQ_HOLD;
            cnt <= CW'(1);
          end
        end
        SQ_HOLD: begin
          if (cnt == LAST_CNT) begin
            st        <= SQ_RUN;
            ctl_rst_q <= 1'b0;
            idx       <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_RUN: begin
          if (idx == LAST_IDX) begin
            st <= SQ_DONE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        SQ_DONE: begin
          done_q <= 1'b1;
        end
        default: st <= SQ_WAIT;
      endcase
    end
  end

  assign step_go_o  = (st == SQ_RUN);
  assign step_idx_o = idx;
  assign ctl_rst_o  = ctl_rst_q;
  assign done_o     = done_q;

  AST_WAIT_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_WAIT && !clk_locked_i) |=> (st == SQ_WAIT)); // R2

  AST_HOLD_KEEPS_RESET: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_HOLD) |-> ctl_rst_q); // R3

  AST_RUN_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_RUN) |-> !done_q); // R8

endmodule

// File: rtl/sdc_step_rom.sv
`timescale 1ns/1ps
module sdc_step_rom
  import sdc_bringup_pkg::*;
#(
  parameter logic [SDC_AW-1:0]   CMD_ADR   = 1'b0,
  parameter logic [SDC_AW-1:0]   ARG_ADR   = 1'b1,
  parameter logic [7:0]          DIVIDER   = 8'h0B,
  parameter logic [SDC_DW-9:0]   CFG_UPPER = 24'h555655,
  parameter logic [7:0]          CFG_OP    = 8'hC0,
  parameter logic [7:0]          IDLE_OP   = 8'h40,
  parameter logic [SDC_DW-1:0]   FILL_WORD = 32'hFFFF_FFFF
) (
  input  logic [SDC_IW-1:0] idx_i,
  output bus_step_t         step_o
);

  localparam logic [SDC_DW-1:0] CFG_WORD = {CFG_UPPER, DIVIDER};
  localparam logic [SDC_DW-1:0] CFG_CMD  = {{(SDC_DW-8){1'b0}}, CFG_OP};
  localparam logic [SDC_DW-1:0] IDLE_CMD = {{(SDC_DW-8){1'b0}}, IDLE_OP};

  bus_step_t prog [SDC_NSTEPS];

  // slot order is behaviour: argument first, a one-slot gap, then the
  // configuration command, then argument and card command back to back
  for (genvar g = 0; g < SDC_NSTEPS; g++) begin : g_slot
    always_comb begin
      case (g)
        0:       prog[g] = mk_write(ARG_ADR, CFG_WORD);
        1:       prog[g] = mk_gap();
        2:       prog[g] = mk_write(CMD_ADR, CFG_CMD);
        3:       prog[g] = mk_write(ARG_ADR, FILL_WORD);
        4:       prog[g] = mk_write(CMD_ADR, IDLE_CMD);
        default: prog[g] = mk_gap();
      endcase
    end
  end

  always_comb begin
    if (int'(idx_i) < SDC_NSTEPS) step_o = prog[idx_i];
    else                          step_o = mk_gap();
  end

endmodule

// File: rtl/sdc_wb_drive.sv
`timescale 1ns/1ps
module sdc_wb_drive
  import sdc_bringup_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  bus_step_t         step_i,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic [SDC_AW-1:0] wb_adr_o,
  output logic [SDC_DW-1:0] wb_dat_o,
  output logic [SDC_SW-1:0] wb_sel_o
);

  logic issue;
  assign issue = go_i && step_i.wr;

  always_ff @(posedge clk) begin
    if (rst || !issue) begin
      wb_cyc_o <= 1'b0;
      wb_stb_o <= 1'b0;
      wb_we_o  <= 1'b0;
      wb_adr_o <= '0;
      wb_dat_o <= '0;
      wb_sel_o <= '0;
    end else begin
      wb_cyc_o <= 1'b1;
      wb_stb_o <= 1'b1;
      wb_we_o  <= 1'b1;
      wb_adr_o <= step_i.adr;
      wb_dat_o <= step_i.dat;
      wb_sel_o <= '1;
    end
  end

  AST_STB_HAS_CYC_WE: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o |-> (wb_cyc_o && wb_we_o)); // R10

  AST_STB_ALL_BYTES: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o |-> (&wb_sel_o)); // R4

  AST_BACK_TO_BACK_ALT: assert property (@(posedge clk) disable iff (rst)
    (wb_stb_o && $past(wb_stb_o)) |-> (wb_adr_o != $past(wb_adr_o))); // R6

endmodule

// File: rtl/sdc_bringup_seq.sv
`timescale 1ns/1ps
module sdc_bringup_seq
  import sdc_bringup_pkg::*;
#(
  parameter int unsigned        HOLD_CYCLES = 5,
  parameter logic [7:0]         DIVIDER     = 8'h0B,
  parameter logic [SDC_DW-9:0]  CFG_UPPER   = 24'h555655,
  parameter logic [7:0]         CFG_OP      = 8'hC0,
  parameter logic [7:0]         IDLE_OP     = 8'h40,
  parameter logic [SDC_DW-1:0]  FILL_WORD   = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_locked_i,
  output logic              ctl_rst_o,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic [SDC_AW-1:0] wb_adr_o,
  output logic [SDC_DW-1:0] wb_dat_o,
  output logic [SDC_SW-1:0] wb_sel_o,
  output logic              done_o
);

  logic              step_go;
  logic [SDC_IW-1:0] step_idx;
  bus_step_t         step;

  sdc_seq_ctrl #(
    .HOLD_CYCLES (HOLD_CYCLES)
  ) i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .clk_locked_i (clk_locked_i),
    .step_go_o    (step_go),
    .step_idx_o   (step_idx),
    .ctl_rst_o    (ctl_rst_o),
    .done_o       (done_o)
  );

  sdc_step_rom #(
    .CMD_ADR   (1'b0),
    .ARG_ADR   (1'b1),
    .DIVIDER   (DIVIDER),
    .CFG_UPPER (CFG_UPPER),
    .CFG_OP    (CFG_OP),
    .IDLE_OP   (IDLE_OP),
    .FILL_WORD (FILL_WORD)
  ) i_rom (
    .idx_i  (step_idx),
    .step_o (step)
  );

  sdc_wb_drive i_drive (
    .clk      (clk),
    .rst      (rst),
    .go_i     (step_go),
    .step_i   (step),
    .wb_cyc_o (wb_cyc_o),
    .wb_stb_o (wb_stb_o),
    .wb_we_o  (wb_we_o),
    .wb_adr_o (wb_adr_o),
    .wb_dat_o (wb_dat_o),
    .wb_sel_o (wb_sel_o)
  );

  AST_NO_BUS_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    ctl_rst_o |-> !wb_stb_o); // R3

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !wb_stb_o); // R8

  AST_CYC_ONLY_WITH_STB: assert property (@(posedge clk) disable iff (rst)
    wb_cyc_o |-> wb_stb_o); // R10

endmodule

// File: tb/test_sdc_bringup_seq.sv
`timescale 1ns/1ps
module test_sdc_bringup_seq;

  localparam int NLOG = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clk_locked_i = 1'b0;
  logic        ctl_rst_o, wb_cyc_o, wb_stb_o, wb_we_o, done_o;
  logic [0:0]  wb_adr_o;
  logic [31:0] wb_dat_o;
  logic [3:0]  wb_sel_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic        lg_stb [NLOG];
  logic        lg_cyc [NLOG];
  logic        lg_we  [NLOG];
  logic        lg_rst [NLOG];
  logic        lg_done[NLOG];
  logic [0:0]  lg_adr [NLOG];
  logic [31:0] lg_dat [NLOG];
  logic [3:0]  lg_sel [NLOG];

  always #4 clk = ~clk;

  sdc_bringup_seq #(.HOLD_CYCLES(5)) i_sdc_bringup_seq (
    .clk          (clk),
    .rst          (rst),
    .clk_locked_i (clk_locked_i),
    .ctl_rst_o    (ctl_rst_o),
    .wb_cyc_o     (wb_cyc_o),
    .wb_stb_o     (wb_stb_o),
    .wb_we_o      (wb_we_o),
    .wb_adr_o     (wb_adr_o),
    .wb_dat_o     (wb_dat_o),
    .wb_sel_o     (wb_sel_o),
    .done_o       (done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    clk_locked_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // raise lock at a falling edge; sample k is taken after edge Ek
  task automatic run_log(input int ncyc, input bit drop_lock);
    clk_locked_i = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      lg_stb[k]  = wb_stb_o;
      lg_cyc[k]  = wb_cyc_o;
      lg_we[k]   = wb_we_o;
      lg_rst[k]  = ctl_rst_o;
      lg_done[k] = done_o;
      lg_adr[k]  = wb_adr_o;
      lg_dat[k]  = wb_dat_o;
      lg_sel[k]  = wb_sel_o;
      if (drop_lock && k == 0) clk_locked_i = 1'b0;
    end
  endtask

  task automatic chk_write(input int k, input string req, input logic [0:0] a,
                           input logic [31:0] d);
    chk(lg_stb[k] === 1'b1, req, $sformatf("strobe at slot %0d", k), 32'(lg_stb[k]), 1);
    chk(lg_adr[k] === a, req, $sformatf("address at slot %0d", k), 32'(lg_adr[k]), 32'(a));
    chk(lg_dat[k] === d, req, $sformatf("data at slot %0d", k), lg_dat[k], d);
    chk(lg_sel[k] === 4'hF, req, $sformatf("byte selects at slot %0d", k), 32'(lg_sel[k]), 32'hF);
  endtask

  task automatic chk_timeline(input int ncyc);
    int nstb = 0;
    for (int k = 0; k < ncyc; k++) begin
      if (k <= 3)
        chk(lg_rst[k] === 1'b1, "R3", $sformatf("ctl reset held at slot %0d", k), 32'(lg_rst[k]), 1);
      else
        chk(lg_rst[k] === 1'b0, "R3", $sformatf("ctl reset released at slot %0d", k), 32'(lg_rst[k]), 0);
      if (k < 5)
        chk(lg_stb[k] === 1'b0, "R3", $sformatf("no strobe before release, slot %0d", k), 32'(lg_stb[k]), 0);
      if (lg_stb[k] === 1'b1) begin
        nstb++;
        chk(lg_cyc[k] === 1'b1 && lg_we[k] === 1'b1, "R10",
            $sformatf("cyc/we with strobe at slot %0d", k), 32'({lg_cyc[k], lg_we[k]}), 32'h3);
      end else begin
        chk(lg_cyc[k] === 1'b0, "R10", $sformatf("cyc low without strobe at slot %0d", k),
            32'(lg_cyc[k]), 0);
      end
      if (k < 10)
        chk(lg_done[k] === 1'b0, "R8", $sformatf("done low at slot %0d", k), 32'(lg_done[k]), 0);
      else begin
        chk(lg_done[k] === 1'b1, "R8", $sformatf("done high at slot %0d", k), 32'(lg_done[k]), 1);
        chk(lg_stb[k] === 1'b0, "R8", $sformatf("quiet after done, slot %0d", k), 32'(lg_stb[k]), 0);
      end
    end
    chk_write(5, "R4", 1'b1, 32'h5556_550B);
    chk(lg_we[5] === 1'b1, "R4", "write enable on first write", 32'(lg_we[5]), 1);
    chk(lg_stb[6] === 1'b0, "R5", "gap after first write", 32'(lg_stb[6]), 0);
    chk_write(7, "R6", 1'b0, 32'h0000_00C0);
    chk_write(8, "R6", 1'b1, 32'hFFFF_FFFF);
    chk_write(9, "R6", 1'b0, 32'h0000_0040);
    chk(nstb == 4, "R7", "total write strobes", 32'(nstb), 4);
    chk(lg_adr[8] === 1'b1 && lg_adr[9] === 1'b0, "R7", "argument precedes card command",
        32'({lg_adr[8], lg_adr[9]}), 32'h2);
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    clk_locked_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(wb_stb_o === 1'b0 && wb_cyc_o === 1'b0 && wb_we_o === 1'b0, "R1",
        "bus idle in reset", 32'({wb_stb_o, wb_cyc_o, wb_we_o}), 0);
    chk(ctl_rst_o === 1'b1, "R1", "ctl reset in reset", 32'(ctl_rst_o), 1);
    chk(done_o === 1'b0, "R1", "done in reset", 32'(done_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(wb_stb_o === 1'b0 && ctl_rst_o === 1'b1 && done_o === 1'b0, "R1",
        "state after reset release", 32'({wb_stb_o, ctl_rst_o, done_o}), 32'h2);
  endtask

  task automatic t_wait_lock();
    int bad = 0;
    do_reset();
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (wb_stb_o !== 1'b0 || ctl_rst_o !== 1'b1 || done_o !== 1'b0) bad++;
    end
    chk(bad == 0, "R2", "no progress without lock", 32'(bad), 0);
  endtask

  task automatic t_full_sequence();
    do_reset();
    run_log(20, 1'b0);
    chk_timeline(20);
  endtask

  task automatic t_lock_drop();
    do_reset();
    run_log(16, 1'b1);
    chk(lg_done[15] === 1'b1, "R9", "completes after lock loss", 32'(lg_done[15]), 1);
    chk_timeline(16);
  endtask

  task automatic t_mid_reset();
    int bad = 0;
    do_reset();
    run_log(8, 1'b0);
    chk(lg_stb[7] === 1'b1, "R11", "write in progress before reset", 32'(lg_stb[7]), 1);
    rst = 1'b1;
    clk_locked_i = 1'b0;
    @(negedge clk);
    chk(wb_stb_o === 1'b0 && ctl_rst_o === 1'b1 && done_o === 1'b0, "R11",
        "outputs after mid-sequence reset", 32'({wb_stb_o, ctl_rst_o, done_o}), 32'h2);
    rst = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (wb_stb_o !== 1'b0 || ctl_rst_o !== 1'b1) bad++;
    end
    chk(bad == 0, "R11", "waits for lock after reset", 32'(bad), 0);
    run_log(16, 1'b0);
    chk_timeline(16);
  endtask

  initial begin
    t_reset_state();
    t_wait_lock();
    t_full_sequence();
    t_lock_drop();
    t_mid_reset();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule